// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a processor core and decides which request, if any, the core takes next. Every source has a level from software (0 is the most urgent) and a fixed rank given by its index (a lower index ranks higher). Arbitration compares the levels first and uses the rank only to break a tie between sources at the same level.

The controller keeps a mask of the levels now in service. A request nests on top of the current service only if its level is strictly more urgent than every level in the mask and the core has interrupts enabled. Other requests wait for as long as their lines stay high. When the core signals the end of a service, the most urgent in-service level is retired. Requests that were waiting then compete again, and the winner is picked by level and then by rank, not by the order in which the requests arrived.

Top module: `nestIntCtrl`

## Requirements
- R1: Among eligible waiting requests, the one whose level number is smallest is acknowledged first, even if it was raised after the others.
- R2: Among eligible waiting requests that share the smallest level, the source with the lowest index is acknowledged, whatever the arrival order.
- R3: While `intEnable` is low no acknowledge is issued. Requests whose lines stay high are acknowledged once `intEnable` returns high.
- R4: With `intEnable` high, a request whose level number is strictly smaller than the smallest set bit position of `svcMask` (or any request when `svcMask` is zero) is acknowledged at once. It nests, and `svcMask` then has both level bits set.
- R5: A request whose level number is equal to or larger than the smallest set bit position of `svcMask` is not acknowledged. It waits while its line stays high.
- R6: `ackPulse` is high for one cycle per acknowledge, and `ackIndex` then holds the chosen source's index. At the same clock edge, bit L of `svcMask` (L being the source's level) is set.
- R7: A one-cycle `eoiStrobe` clears the lowest-numbered set bit of `svcMask`. Waiting requests that become eligible as a result are acknowledged on the following edge.
- R8: Requests are level-sensitive. A source whose line drops before it is acknowledged is never acknowledged for that request.
- R9: After reset, `ackPulse` is 0 and `svcMask` is 0. A request line raised before a clock edge is registered at that edge. When that request is eligible, the acknowledge appears at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | NUM_SRC | Level-sensitive request line per source |
| srcLevel | input | NUM_SRC*LVL_W | Level of source i in bits [i*LVL_W +: LVL_W], 0 most urgent |
| intEnable | input | 1 | Core interrupt-enable state (1 enabled, 0 disabled) |
| eoiStrobe | input | 1 | One-cycle end-of-service strobe from the core |
| ackPulse | output | 1 | One-cycle acknowledge to the core |
| ackIndex | output | SRC_W | Index of the acknowledged source, valid with ackPulse |
| svcMask | output | NUM_LVL | In-service levels, bit L for level L |

## Verification
The bench builds the controller with 8 sources and 4 levels. This size makes it cheap to visit every ordered pair of distinct sources under all 16 level combinations. That sweep covers both the level comparison and the index tie-break in both directions, as well as the wait of the losing request until the end-of-service strobe. A second sweep serves one source at each level and then raises another at each level, which covers every preempt-or-wait decision against a one-level mask. The single-source sweep puts every source at every level, so each bit of the level field and of `svcMask` is exercised.

// File: rtl/nicPkg.sv
package nicPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;      // take the current candidate this edge
  } nicStrobe_t;

endpackage

// File: rtl/nicDatapath.sv
module nicDatapath
  import nicPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_LVL = 4,
  parameter int SRC_W   = $clog2(NUM_SRC),
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqLines,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic [NUM_LVL-1:0]       lvlAllow,
  input  nicStrobe_t               strobe,
  output logic                     candValid,
  output logic [LVL_W-1:0]         candLvl,
  output logic                     ackPulse,
  output logic [SRC_W-1:0]         ackIndex
);

  logic [NUM_SRC-1:0]              pendQ;
  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvlHit;
  logic [NUM_LVL-1:0]              lvlLive;
  logic [NUM_SRC-1:0]              winSet;
  logic [SRC_W-1:0]                candIdx;
  logic [NUM_SRC-1:0]              grantVec;

  // Sort pending sources into one bit-vector per level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign lvlHit[l][s] = pendQ[s] &&
                            (srcLevel[s*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign lvlLive[l] = lvlAllow[l] && (|lvlHit[l]);
  end

  // Most urgent live level: lowest index wins
  always_comb begin
    candValid = 1'b0;
    candLvl   = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (lvlLive[l]) begin
        candValid = 1'b1;
        candLvl   = LVL_W'(l);
      end
    end
  end

  // Tie-break inside the chosen level: lowest source index
  assign winSet = lvlHit[candLvl];

  always_comb begin
    candIdx = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (winSet[s]) candIdx = SRC_W'(s);
    end
  end

  always_comb begin
    grantVec = '0;
    if (strobe.issue) grantVec[candIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      ackPulse <= 1'b0;
      ackIndex <= '0;
    end else begin
      // Level-sensitive: pending follows the line, minus the granted source
      pendQ    <= reqLines & ~grantVec;
      ackPulse <= strobe.issue;
      if (strobe.issue) ackIndex <= candIdx;
    end
  end

endmodule

// File: rtl/nicControl.sv
module nicControl
  import nicPkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               intEnable,
  input  logic               eoiStrobe,
  input  logic               candValid,
  input  logic [LVL_W-1:0]   candLvl,
  output logic [NUM_LVL-1:0] lvlAllow,
  output nicStrobe_t         strobe,
  output logic [NUM_LVL-1:0] svcMask
);

  logic [NUM_LVL-1:0] svcQ;
  logic [NUM_LVL-1:0] lowBit;
  logic [NUM_LVL-1:0] setBit;
  logic [NUM_LVL-1:0] clrBit;

  // A level may be taken only if no equal or more urgent level is in service
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_allow
    assign lvlAllow[l] = intEnable && (svcQ[l:0] == '0);
  end

  assign strobe.issue = candValid;

  // Isolate the most urgent in-service level
  assign lowBit = svcQ & (~svcQ + NUM_LVL'(1));
  assign clrBit = eoiStrobe ? lowBit : '0;

  always_comb begin
    setBit = '0;
    if (strobe.issue) setBit[candLvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) svcQ <= '0;
    else       svcQ <= (svcQ & ~clrBit) | setBit;
  end

  assign svcMask = svcQ;

endmodule

// File: rtl/nestIntCtrl.sv
module nestIntCtrl
  import nicPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_LVL = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqLines,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic                     intEnable,
  input  logic                     eoiStrobe,
  output logic                     ackPulse,
  output logic [SRC_W-1:0]         ackIndex,
  output logic [NUM_LVL-1:0]       svcMask
);

  nicStrobe_t         strobe;
  logic               candValid;
  logic [LVL_W-1:0]   candLvl;
  logic [NUM_LVL-1:0] lvlAllow;

  nicDatapath #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .SRC_W(SRC_W), .LVL_W(LVL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .srcLevel(srcLevel),
    .lvlAllow(lvlAllow), .strobe(strobe), .candValid(candValid),
    .candLvl(candLvl), .ackPulse(ackPulse), .ackIndex(ackIndex)
  );

  nicControl #(
    .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .eoiStrobe(eoiStrobe),
    .candValid(candValid), .candLvl(candLvl), .lvlAllow(lvlAllow),
    .strobe(strobe), .svcMask(svcMask)
  );

endmodule

// File: rtl/nicChecker.sv
module nicChecker #(
  parameter int NUM_SRC = 16,
  parameter int NUM_LVL = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_SRC-1:0]       reqLines,
  input logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input logic                     intEnable,
  input logic                     eoiStrobe,
  input logic                     ackPulse,
  input logic [SRC_W-1:0]         ackIndex,
  input logic [NUM_LVL-1:0]       svcMask
);

  logic [NUM_SRC-1:0]       reqQ, reqQQ;
  logic [NUM_SRC*LVL_W-1:0] lvlQ;
  logic [NUM_LVL-1:0]       svcQ;
  logic                     eiQ, eoiQ;
  logic [LVL_W-1:0]         ackLvlQ;

  always_ff @(posedge clk) begin
    reqQ  <= reqLines;
    reqQQ <= reqQ;
    lvlQ  <= srcLevel;
    svcQ  <= svcMask;
    eiQ   <= intEnable;
    eoiQ  <= eoiStrobe;
  end

  assign ackLvlQ = lvlQ[ackIndex*LVL_W +: LVL_W];

  function automatic int topLvl(input logic [NUM_LVL-1:0] m);
    int r = NUM_LVL;
    for (int l = NUM_LVL - 1; l >= 0; l--) if (m[l]) r = l;
    return r;
  endfunction

  AST_ACK_NEEDS_EI: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> eiQ);  // R3
  AST_ACK_ABOVE_SVC: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (int'(ackLvlQ) < topLvl(svcQ)));  // R4
  AST_SAME_LVL_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !svcQ[ackLvlQ]);  // R5
  AST_ACK_SETS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> svcMask[ackLvlQ]);  // R6
  AST_NO_SVC_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    !ackPulse |-> ($countones(svcMask) <= $countones(svcQ)));  // R6
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (eoiQ && (svcQ != '0) && !ackPulse) |->
      ($countones(svcMask) == $countones(svcQ) - 1));  // R7
  AST_ACK_WAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> reqQQ[ackIndex]);  // R8

endmodule

bind nestIntCtrl nicChecker #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) chk_i (
  .clk(clk), .rstN(rstN), .reqLines(reqLines), .srcLevel(srcLevel),
  .intEnable(intEnable), .eoiStrobe(eoiStrobe), .ackPulse(ackPulse),
  .ackIndex(ackIndex), .svcMask(svcMask)
);

// File: tb/nestIntCtrl_tb.sv
module nestIntCtrl_tb_top;
  localparam int NS = 8;
  localparam int NL = 4;
  localparam int SW = $clog2(NS);
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] reqV = '0;
  logic [NS*LW-1:0] lvlV = '0;
  logic          ei = 1'b0;
  logic          eoi = 1'b0;
  logic          ackPulse;
  logic [SW-1:0] ackIndex;
  logic [NL-1:0] svcMask;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nestIntCtrl #(.NUM_SRC(NS), .NUM_LVL(NL)) dut_i (
    .clk(clk), .rstN(rstN), .reqLines(reqV), .srcLevel(lvlV),
    .intEnable(ei), .eoiStrobe(eoi), .ackPulse(ackPulse),
    .ackIndex(ackIndex), .svcMask(svcMask)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ack observed with index: encode as idx+1, 0 meaning no ack
  function automatic int ackCode();
    return ackPulse ? int'(ackIndex) + 1 : 0;
  endfunction

  task automatic setLvl(input int s, input int l);
    lvlV[s*LW +: LW] = LW'(l);
  endtask

  task automatic endSvc();
    eoi = 1'b1; tick(); eoi = 1'b0; tick();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    chk("R9 reset ack", int'(ackPulse), 0);
    chk("R9 reset svc", int'(svcMask), 0);
    rstN = 1'b1;
    tick();

    // Single source at every level
    for (int s = 0; s < NS; s++) begin
      for (int l = 0; l < NL; l++) begin
        setLvl(s, l); ei = 1'b1; reqV = '0; reqV[s] = 1'b1;
        tick(); tick();
        chk("R9 latency", ackCode(), s + 1);
        chk("R6 svc bit", int'(svcMask), 1 << l);
        reqV = '0; tick();
        chk("R6 one-cycle", int'(ackPulse), 0);
        endSvc();
        chk("R7 svc clear", int'(svcMask), 0);
      end
    end

    // Every ordered pair under every level pair
    for (int a = 0; a < NS; a++) begin
      for (int b = 0; b < NS; b++) begin
        if (a == b) continue;
        for (int la = 0; la < NL; la++) begin
          for (int lb = 0; lb < NL; lb++) begin
            int w, o, lw, lo;
            if (la < lb)      begin w = a; o = b; end
            else if (lb < la) begin w = b; o = a; end
            else if (a < b)   begin w = a; o = b; end
            else              begin w = b; o = a; end
            lw = (w == a) ? la : lb;
            lo = (w == a) ? lb : la;
            ei = 1'b0; setLvl(a, la); setLvl(b, lb);
            reqV = '0; reqV[a] = 1'b1; reqV[b] = 1'b1;
            tick(); tick(); tick();
            chk("R3 held while disabled", ackCode(), 0);
            ei = 1'b1; tick();
            chk((la != lb) ? "R1 level order" : "R2 index tie", ackCode(), w + 1);
            chk("R6 svc after first", int'(svcMask), 1 << lw);
            tick(); tick();
            chk("R5 loser waits", ackCode(), 0);
            reqV[w] = 1'b0;
            endSvc();
            chk("R7 loser taken", ackCode(), o + 1);
            chk("R7 svc after second", int'(svcMask), 1 << lo);
            reqV = '0;
            endSvc();
            chk("R7 svc empty", int'(svcMask), 0);
          end
        end
      end
    end

    // Nesting against one in-service level
    for (int li = 0; li < NL; li++) begin
      for (int ln = 0; ln < NL; ln++) begin
        setLvl(2, li); setLvl(5, ln); ei = 1'b1;
        reqV = '0; reqV[2] = 1'b1;
        tick(); tick();
        chk("R9 first service", ackCode(), 3);
        reqV = '0; reqV[5] = 1'b1;
        tick(); tick();
        if (ln < li) begin
          chk("R4 nests", ackCode(), 6);
          chk("R4 both levels", int'(svcMask), (1 << li) | (1 << ln));
          reqV = '0;
          endSvc();
          chk("R7 inner retired", int'(svcMask), 1 << li);
          endSvc();
          chk("R7 outer retired", int'(svcMask), 0);
        end else begin
          chk("R5 no preempt", ackCode(), 0);
          chk("R5 svc unchanged", int'(svcMask), 1 << li);
          endSvc();
          chk("R7 waiting taken", ackCode(), 6);
          chk("R7 svc now new", int'(svcMask), 1 << ln);
          reqV = '0;
          endSvc();
          chk("R7 svc empty", int'(svcMask), 0);
        end
      end
    end

    // Request dropped before acknowledge
    begin
      bit sawAck = 1'b0;
      ei = 1'b0; setLvl(3, 1); reqV = '0; reqV[3] = 1'b1;
      tick(); tick();
      reqV = '0; tick();
      ei = 1'b1;
      for (int k = 0; k < 4; k++) begin
        tick();
        if (ackPulse) sawAck = 1'b1;
      end
      chk("R8 dropped request", int'(sawAck), 0);
      chk("R8 svc untouched", int'(svcMask), 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule